// File: doc/BRIEF.md
# QAM Symbol Demapper and Output Formatter

This block turns decided QAM symbols into data bits and presents them on an 8-bit output port. Each symbol arrives as a pair of unsigned level indices, one for the in-phase axis and one for the quadrature axis, together with a one-cycle symbol strobe. The block works out the quadrant of the symbol and the position of the symbol inside that quadrant. It builds a data byte under one of four selectable demapping schemes. The byte, or the raw level pair, is then sent out in one of three formats: a whole byte per symbol, four 2-bit slots per symbol, or an I word followed by a Q word.

The quadrant bits can be decoded differentially. In that case the top two bits carry the quadrant change since the previous symbol, so a constant phase rotation of the whole constellation has no effect on the data. The in-quadrant bits are taken after each symbol is rotated back into a common reference quadrant, which also makes them rotation-invariant. The output side is a small state machine clocked by the system clock. Each sub-symbol slot lasts one clock cycle. A data-valid pulse marks the start of every symbol. A slot clock marks every slot of the sub-symbol formats.

The modulation codes on `mode` are 0 = 4-QAM, 1 = 16-QAM, 2 = 32-QAM, 3 = 64-QAM and 4 = 256-QAM. The scheme codes on `scheme` are 0 = differential, 1 = direct, 2 = Gray-direct and 3 = absolute-quadrant. The format codes on `fmt` are 0 = parallel, 1 = semi-serial, 2 = I/Q multiplexed and 3 = parallel. Quadrants are numbered counter-clockwise, each with its Gray code: Q0 (I high, Q high) = 00, Q1 (I low, Q high) = 01, Q2 (I low, Q low) = 11, Q3 (I high, Q low) = 10. An index is "high" when it is at least the mode's half value. The half values are 1, 2, 3, 4 and 8 for 4, 16, 32, 64 and 256-QAM. Offsets are measured from the axis: the distance a = i - half when I is high, and a = half - 1 - i when I is low. The distance b is formed the same way from the Q index. The rotated offsets are (u, v) = (a, b) in Q0 and Q2 and (u, v) = (b, a) in Q1 and Q3. G(x) = x XOR (x >> 1) denotes the Gray code of x.

Formatter states:
- ST_IDLE: the outputs are zero.
- ST_PAR_NEW: the byte is shown with a data-valid pulse.
- ST_PAR_HOLD: the byte is held.
- ST_SER0, ST_SER1, ST_SER2, ST_SER3: the four semi-serial slots.
- ST_MUX_I and ST_MUX_Q: the two multiplexed words.

Transitions:
- A strobe in any state enters ST_PAR_NEW (fmt 0 or 3), ST_SER0 (fmt 1) or ST_MUX_I (fmt 2).
- Without a strobe, ST_PAR_NEW goes to ST_PAR_HOLD, and ST_PAR_HOLD stays where it is.
- Without a strobe, ST_SER0 goes to ST_SER1, then ST_SER2, then ST_SER3, then ST_IDLE.
- Without a strobe, ST_MUX_I goes to ST_MUX_Q, then ST_IDLE.
- Without a strobe, ST_IDLE stays where it is.

Top module: `qam_demap_fmt`

## Requirements
- R1: While reset is held and in the first cycle after it, dout, sdv and oclk are all 0.
- R2: In scheme 0, b7..b6 = G((quadrant − previous quadrant) mod 4). The previous quadrant resets to Q0 and is updated on every strobe, whatever the scheme and format.
- R3: In scheme 0 and scheme 3, the low bits b5..b0 depend on the mode. 4-QAM gives 0. 16-QAM gives {u[0], v[0], 0000}. 64-QAM gives {G(u)[1:0], G(v)[1:0], 00}. 256-QAM gives {G(u)[2:1], G(v)[2:1], 00}.
- R4: In scheme 0 and scheme 3, a 32-QAM symbol gives the byte 0x00, and it still updates the previous quadrant.
- R5: In scheme 3, b7..b6 = G(quadrant), and b5..b0 follow R3.
- R6: In scheme 1, the byte is {i_lvl, q_lvl} in every mode.
- R7: In scheme 2, the byte is {G(i_lvl), G(q_lvl)} in every mode.
- R8: In fmt 0 or fmt 3, the cycle after a strobe shows dout = byte, sdv = 1 and oclk = 0. The following cycles hold the same dout, with sdv = 0 and oclk = 0, until the next strobe.
- R9: In fmt 1, the four cycles after a strobe show dout = {000000, pair} with oclk = 1. The pairs are b7b6, b5b4, b3b2 and b1b0, in that order. sdv = 1 in the first slot only. After the fourth slot, all outputs are 0.
- R10: In fmt 2, the cycle after a strobe shows dout = {0000, i_lvl} with sdv = 1 and oclk = 1. The next cycle shows dout = {0000, q_lvl} with sdv = 0 and oclk = 1. After that, all outputs are 0.
- R11: A strobe that arrives while a sequence is still running aborts it. The new symbol's first output appears in the cycle that follows.
- R12: Mode codes 5, 6 and 7 behave exactly like 4-QAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one sub-symbol slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | One-cycle strobe for a decided symbol |
| i_lvl | input | 4 | In-phase level index |
| q_lvl | input | 4 | Quadrature level index |
| mode | input | 3 | Modulation code |
| scheme | input | 2 | Demapping scheme code |
| fmt | input | 2 | Output format code |
| dout | output | 8 | Output data |
| sdv | output | 1 | Symbol data-valid pulse |
| oclk | output | 1 | Slot clock for the sub-symbol formats |

## Verification
The assertions take for granted that the inputs are sampled only when the strobe is high. They also take for granted that the level indices stay inside the grid of the selected mode: below twice the half value, so 0..5 for 32-QAM. Finally, they assume the strobes are spaced far enough apart for the chosen format to finish, except where an abort is intended. The stimulus picks each index modulo the mode's grid size. It waits for each sequence to complete before the next strobe, and it breaks that spacing only in the directed abort case.

// File: rtl/qam_fmt_pkg.sv
package qam_fmt_pkg;

    typedef enum logic [2:0] {
        QM_4   = 3'd0,
        QM_16  = 3'd1,
        QM_32  = 3'd2,
        QM_64  = 3'd3,
        QM_256 = 3'd4
    } qmode_e;

    typedef enum logic [1:0] {
        SCH_DIFF  = 2'd0,
        SCH_DIRECT = 2'd1,
        SCH_GRAY  = 2'd2,
        SCH_ABS   = 2'd3
    } scheme_e;

    typedef enum logic [1:0] {
        FMT_PAR  = 2'd0,
        FMT_SER  = 2'd1,
        FMT_MUX  = 2'd2,
        FMT_PAR2 = 2'd3
    } fmt_e;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_PAR_NEW  = 4'd1,
        ST_PAR_HOLD = 4'd2,
        ST_SER0     = 4'd3,
        ST_SER1     = 4'd4,
        ST_SER2     = 4'd5,
        ST_SER3     = 4'd6,
        ST_MUX_I    = 4'd7,
        ST_MUX_Q    = 4'd8
    } fmt_state_e;

    function automatic logic [1:0] quad_gray(input logic [1:0] n);
        return n ^ (n >> 1);
    endfunction

endpackage

// File: rtl/qam_quad_tracker.sv
module qam_quad_tracker
    import qam_fmt_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [LVL_W-1:0] i_lvl,
    input  logic [LVL_W-1:0] q_lvl,
    input  qmode_e           mode,
    output logic [1:0]       quad_now,
    output logic [1:0]       quad_step,
    output logic [LVL_W-2:0] rot_u,
    output logic [LVL_W-2:0] rot_v
);
    localparam int OFS_W = LVL_W - 1;

    logic [LVL_W-1:0] half;
    logic             i_hi, q_hi;
    logic [LVL_W-1:0] dist_i, dist_q;
    logic [1:0]       prev_q;

    always_comb begin
        unique case (mode)
            QM_16:   half = LVL_W'(2);
            QM_32:   half = LVL_W'(3);
            QM_64:   half = LVL_W'(4);
            QM_256:  half = LVL_W'(1 << (LVL_W - 1));
            default: half = LVL_W'(1);
        endcase
    end

    always_comb begin
        i_hi   = (i_lvl >= half);
        q_hi   = (q_lvl >= half);
        dist_i = i_hi ? (i_lvl - half) : (half - LVL_W'(1) - i_lvl);
        dist_q = q_hi ? (q_lvl - half) : (half - LVL_W'(1) - q_lvl);
        unique case ({i_hi, q_hi})
            2'b11: quad_now = 2'd0;
            2'b01: quad_now = 2'd1;
            2'b00: quad_now = 2'd2;
            default: quad_now = 2'd3;
        endcase
        if (quad_now[0]) begin
            rot_u = dist_q[OFS_W-1:0];
            rot_v = dist_i[OFS_W-1:0];
        end else begin
            rot_u = dist_i[OFS_W-1:0];
            rot_v = dist_q[OFS_W-1:0];
        end
        quad_step = quad_now - prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 2'd0;
        else if (sym_valid)
            prev_q <= quad_now;
    end

    // R2
    repeat_quadrant_zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && $past(sym_valid) && $stable(quad_now)) |-> (quad_step == 2'd0));

endmodule

// File: rtl/qam_bit_mapper.sv
module qam_bit_mapper
    import qam_fmt_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  qmode_e           mode,
    input  scheme_e          scheme,
    input  logic [LVL_W-1:0] i_lvl,
    input  logic [LVL_W-1:0] q_lvl,
    input  logic [1:0]       quad_now,
    input  logic [1:0]       quad_step,
    input  logic [LVL_W-2:0] rot_u,
    input  logic [LVL_W-2:0] rot_v,
    output logic [2*LVL_W-1:0] sym_byte
);
    localparam int BYTE_W = 2 * LVL_W;
    localparam int LOW_W  = BYTE_W - 2;

    logic [LVL_W-2:0] gu, gv;
    logic [LOW_W-1:0] low_bits;
    logic [1:0]       top_bits;

    always_comb begin
        gu = rot_u ^ (rot_u >> 1);
        gv = rot_v ^ (rot_v >> 1);
        low_bits = '0;
        unique case (mode)
            QM_16: begin
                low_bits[LOW_W-1] = rot_u[0];
                low_bits[LOW_W-2] = rot_v[0];
            end
            QM_64: begin
                low_bits[LOW_W-1 -: 2] = gu[1:0];
                low_bits[LOW_W-3 -: 2] = gv[1:0];
            end
            QM_256: begin
                low_bits[LOW_W-1 -: 2] = gu[LVL_W-2 -: 2];
                low_bits[LOW_W-3 -: 2] = gv[LVL_W-2 -: 2];
            end
            default: low_bits = '0;
        endcase
        top_bits = (scheme == SCH_ABS) ? quad_gray(quad_now) : quad_gray(quad_step);
    end

    always_comb begin
        unique case (scheme)
            SCH_DIRECT: sym_byte = {i_lvl, q_lvl};
            SCH_GRAY:   sym_byte = {i_lvl ^ (i_lvl >> 1), q_lvl ^ (q_lvl >> 1)};
            default: begin
                if (mode == QM_32)
                    sym_byte = '0;
                else
                    sym_byte = {top_bits, low_bits};
            end
        endcase
    end

endmodule

// File: rtl/qam_out_fsm.sv
module qam_out_fsm
    import qam_fmt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_valid,
    input  fmt_e              fmt,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [BYTE_W-1:0] iword_in,
    input  logic [BYTE_W-1:0] qword_in,
    output logic [BYTE_W-1:0] dout,
    output logic              sdv,
    output logic              oclk
);
    fmt_state_e        state, state_nx;
    logic [BYTE_W-1:0] byte_r, iword_r, qword_r;

    always_comb begin
        state_nx = state;
        if (sym_valid) begin
            unique case (fmt)
                FMT_SER: state_nx = ST_SER0;
                FMT_MUX: state_nx = ST_MUX_I;
                default: state_nx = ST_PAR_NEW;
            endcase
        end else begin
            unique case (state)
                ST_PAR_NEW:  state_nx = ST_PAR_HOLD;
                ST_PAR_HOLD: state_nx = ST_PAR_HOLD;
                ST_SER0:     state_nx = ST_SER1;
                ST_SER1:     state_nx = ST_SER2;
                ST_SER2:     state_nx = ST_SER3;
                ST_SER3:     state_nx = ST_IDLE;
                ST_MUX_I:    state_nx = ST_MUX_Q;
                ST_MUX_Q:    state_nx = ST_IDLE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            byte_r  <= '0;
            iword_r <= '0;
            qword_r <= '0;
        end else begin
            state <= state_nx;
            if (sym_valid) begin
                byte_r  <= byte_in;
                iword_r <= iword_in;
                qword_r <= qword_in;
            end
        end
    end

    always_comb begin
        dout = '0;
        sdv  = 1'b0;
        oclk = 1'b0;
        unique case (state)
            ST_PAR_NEW:  begin dout = byte_r; sdv = 1'b1; end
            ST_PAR_HOLD: dout = byte_r;
            ST_SER0:     begin dout[1:0] = byte_r[BYTE_W-1 -: 2]; sdv = 1'b1; oclk = 1'b1; end
            ST_SER1:     begin dout[1:0] = byte_r[BYTE_W-3 -: 2]; oclk = 1'b1; end
            ST_SER2:     begin dout[1:0] = byte_r[BYTE_W-5 -: 2]; oclk = 1'b1; end
            ST_SER3:     begin dout[1:0] = byte_r[BYTE_W-7 -: 2]; oclk = 1'b1; end
            ST_MUX_I:    begin dout = iword_r; sdv = 1'b1; oclk = 1'b1; end
            ST_MUX_Q:    begin dout = qword_r; oclk = 1'b1; end
            default:     dout = '0;
        endcase
    end

    // R8
    sdv_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdv |-> $past(sym_valid));

    // R9
    slot_clock_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oclk && !sdv) |-> $past(oclk));

    // R8
    held_output_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!oclk && !sdv && !$past(oclk) && !$past(sym_valid)) |-> $stable(dout));

endmodule

// File: rtl/qam_demap_fmt.sv
module qam_demap_fmt
    import qam_fmt_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [LVL_W-1:0] i_lvl,
    input  logic [LVL_W-1:0] q_lvl,
    input  logic [2:0]       mode,
    input  logic [1:0]       scheme,
    input  logic [1:0]       fmt,
    output logic [2*LVL_W-1:0] dout,
    output logic             sdv,
    output logic             oclk
);
    localparam int BYTE_W = 2 * LVL_W;

    qmode_e            eff_mode;
    scheme_e           sch;
    fmt_e              fmt_sel;
    logic [1:0]        quad_now, quad_step;
    logic [LVL_W-2:0]  rot_u, rot_v;
    logic [BYTE_W-1:0] sym_byte;
    logic [BYTE_W-1:0] iword, qword;

    always_comb begin
        eff_mode = (mode > 3'd4) ? QM_4 : qmode_e'(mode);
        sch      = scheme_e'(scheme);
        fmt_sel  = fmt_e'(fmt);
        iword    = BYTE_W'(i_lvl);
        qword    = BYTE_W'(q_lvl);
    end

    qam_quad_tracker #(.LVL_W(LVL_W)) u_quad (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .i_lvl     (i_lvl),
        .q_lvl     (q_lvl),
        .mode      (eff_mode),
        .quad_now  (quad_now),
        .quad_step (quad_step),
        .rot_u     (rot_u),
        .rot_v     (rot_v)
    );

    qam_bit_mapper #(.LVL_W(LVL_W)) u_map (
        .mode      (eff_mode),
        .scheme    (sch),
        .i_lvl     (i_lvl),
        .q_lvl     (q_lvl),
        .quad_now  (quad_now),
        .quad_step (quad_step),
        .rot_u     (rot_u),
        .rot_v     (rot_v),
        .sym_byte  (sym_byte)
    );

    qam_out_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .fmt       (fmt_sel),
        .byte_in   (sym_byte),
        .iword_in  (iword),
        .qword_in  (qword),
        .dout      (dout),
        .sdv       (sdv),
        .oclk      (oclk)
    );

    // R3
    four_qam_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdv && !oclk && $past(sym_valid && eff_mode == QM_4 &&
                               (sch == SCH_DIFF || sch == SCH_ABS)))
        |-> (dout[BYTE_W-3:0] == '0));

    // R4
    cross_qam_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sdv && !oclk && $past(sym_valid && eff_mode == QM_32 &&
                               (sch == SCH_DIFF || sch == SCH_ABS)))
        |-> (dout == '0));

endmodule

// File: tb/qam_demap_fmt_test.sv
module qam_demap_fmt_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic [3:0] i_lvl = '0, q_lvl = '0;
    logic [2:0] mode = '0;
    logic [1:0] scheme = '0, fmt = '0;
    logic [7:0] dout;
    logic       sdv, oclk;

    int n_checks = 0;
    int n_fail = 0;
    logic [1:0] prevq = 2'd0;

    qam_demap_fmt uut (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid),
        .i_lvl(i_lvl), .q_lvl(q_lvl), .mode(mode),
        .scheme(scheme), .fmt(fmt),
        .dout(dout), .sdv(sdv), .oclk(oclk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int half_of(input logic [2:0] m);
        case (m)
            3'd1: return 2;
            3'd2: return 3;
            3'd3: return 4;
            3'd4: return 8;
            default: return 1;
        endcase
    endfunction

    function automatic logic [1:0] quad_of(input logic [3:0] i, q, input logic [2:0] m);
        int h = half_of(m);
        bit ih = (int'(i) >= h);
        bit qh = (int'(q) >= h);
        if (ih && qh) return 2'd0;
        if (!ih && qh) return 2'd1;
        if (!ih && !qh) return 2'd2;
        return 2'd3;
    endfunction

    function automatic logic [1:0] g2(input logic [1:0] n);
        logic [1:0] tbl [4] = '{2'b00, 2'b01, 2'b11, 2'b10};
        return tbl[n];
    endfunction

    function automatic logic [7:0] model(input logic [3:0] i, q, input logic [2:0] m,
                                         input logic [1:0] s, input logic [1:0] pq);
        int h = half_of(m);
        int a, b, u, v, gu, gv;
        logic [1:0] qd = quad_of(i, q, m);
        logic [5:0] low;
        a = (int'(i) >= h) ? int'(i) - h : h - 1 - int'(i);
        b = (int'(q) >= h) ? int'(q) - h : h - 1 - int'(q);
        if (qd == 2'd1 || qd == 2'd3) begin u = b; v = a; end
        else begin u = a; v = b; end
        gu = u ^ (u >> 1);
        gv = v ^ (v >> 1);
        case (m)
            3'd1: low = {u[0], v[0], 4'b0000};
            3'd3: low = {gu[1:0], gv[1:0], 2'b00};
            3'd4: low = {gu[2:1], gv[2:1], 2'b00};
            default: low = 6'd0;
        endcase
        if (s == 2'd1) return {i, q};
        if (s == 2'd2) return {i ^ (i >> 1), q ^ (q >> 1)};
        if (m == 3'd2) return 8'h00;
        if (s == 2'd3) return {g2(qd), low};
        return {g2(qd - pq), low};
    endfunction

    function automatic logic [2:0] eff(input logic [2:0] m);
        return (m > 3'd4) ? 3'd0 : m;
    endfunction

    task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {sdv,oclk,dout} got %b expected %b", tag, act, exp);
        end
    endtask

    function automatic string scheme_tag(input logic [1:0] s, input logic [2:0] m);
        if (m > 3'd4) return "R12";
        if (m == 3'd2 && (s == 2'd0 || s == 2'd3)) return "R4";
        case (s)
            2'd0: return "R2 R3";
            2'd1: return "R6";
            2'd2: return "R7";
            default: return "R5 R3";
        endcase
    endfunction

    // drives one strobe; the caller is at a negedge afterwards with sym_valid low
    task automatic strobe(input logic [3:0] i, q, input logic [2:0] m,
                          input logic [1:0] s, f, output logic [7:0] eb);
        eb = model(i, q, eff(m), s, prevq);
        prevq = quad_of(i, q, eff(m));
        @(negedge clk);
        i_lvl = i; q_lvl = q; mode = m; scheme = s; fmt = f; sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic send(input logic [3:0] i, q, input logic [2:0] m,
                        input logic [1:0] s, f);
        logic [7:0] eb;
        string t;
        strobe(i, q, m, s, f, eb);
        t = scheme_tag(s, m);
        case (f)
            2'd1: begin
                for (int k = 0; k < 4; k++) begin
                    chk({t, " R9 slot"}, {sdv, oclk, dout},
                        {(k == 0), 1'b1, 6'd0, eb[7-2*k -: 2]});
                    @(negedge clk);
                end
                chk("R9 end", {sdv, oclk, dout}, 10'd0);
            end
            2'd2: begin
                chk("R10 iword", {sdv, oclk, dout}, {2'b11, 4'd0, i});
                @(negedge clk);
                chk("R10 qword", {sdv, oclk, dout}, {2'b01, 4'd0, q});
                @(negedge clk);
                chk("R10 end", {sdv, oclk, dout}, 10'd0);
            end
            default: begin
                chk({t, " R8 new"}, {sdv, oclk, dout}, {2'b10, eb});
                @(negedge clk);
                chk("R8 hold", {sdv, oclk, dout}, {2'b00, eb});
            end
        endcase
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        chk("R1 in reset", {sdv, oclk, dout}, 10'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {sdv, oclk, dout}, 10'd0);

        // R2: quadrant walk in 4-QAM, differential, parallel
        send(4'd1, 4'd1, 3'd0, 2'd0, 2'd0);
        send(4'd0, 4'd1, 3'd0, 2'd0, 2'd0);
        send(4'd1, 4'd0, 3'd0, 2'd0, 2'd0);
        send(4'd0, 4'd0, 3'd0, 2'd0, 2'd0);
        send(4'd0, 4'd0, 3'd0, 2'd0, 2'd3);
        // R3: rotation-invariant 64-QAM points, semi-serial
        send(4'd7, 4'd5, 3'd3, 2'd0, 2'd1);
        send(4'd2, 4'd7, 3'd3, 2'd3, 2'd1);
        // R4: 32-QAM in differential and absolute schemes
        send(4'd5, 4'd0, 3'd2, 2'd0, 2'd0);
        send(4'd1, 4'd4, 3'd2, 2'd3, 2'd0);
        // R12: reserved mode codes
        send(4'd1, 4'd0, 3'd6, 2'd0, 2'd0);
        send(4'd0, 4'd1, 3'd7, 2'd3, 2'd1);
        // R6 R7 R10: 256-QAM direct, Gray and multiplexed
        send(4'd13, 4'd6, 3'd4, 2'd1, 2'd0);
        send(4'd13, 4'd6, 3'd4, 2'd2, 2'd0);
        send(4'd9, 4'd3, 3'd4, 2'd0, 2'd2);

        // R11: abort a semi-serial sequence with a parallel symbol
        begin
            logic [7:0] ea, eb2;
            strobe(4'd12, 4'd2, 3'd4, 2'd0, 2'd1, ea);
            chk("R11 first slot", {sdv, oclk, dout}, {2'b11, 6'd0, ea[7:6]});
            eb2 = model(4'd3, 4'd14, 3'd4, 2'd0, prevq);
            prevq = quad_of(4'd3, 4'd14, 3'd4);
            i_lvl = 4'd3; q_lvl = 4'd14; mode = 3'd4; scheme = 2'd0; fmt = 2'd0;
            sym_valid = 1'b1;
            @(negedge clk);
            sym_valid = 1'b0;
            chk("R11 restart", {sdv, oclk, dout}, {2'b10, eb2});
            @(negedge clk);
            chk("R11 hold", {sdv, oclk, dout}, {2'b00, eb2});
        end

        for (int n = 0; n < 400; n++) begin
            logic [2:0] m = 3'($urandom % 8);
            int sz = 2 * half_of(eff(m));
            logic [3:0] ri = 4'($urandom % sz);
            logic [3:0] rq = 4'($urandom % sz);
            send(ri, rq, m, 2'($urandom % 4), 2'($urandom % 4));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule